// File: doc/BRIEF.md
# Reversible Nonlinear State Accumulator

This block keeps a wide state word and moves it forward by exactly one round for every counter word it accepts. Each round builds a substituted word and then scatters its bits through a fixed bit permutation, all within one clock cycle. The substitution has three tiers:

- the lowest five bits pass through a 5-bit S-box;
- the next five bits get a four-input nonlinear term;
- every higher bit gets a five-input nonlinear term.

Each tier reads only bits below its own position. Because of this, the round can be undone from the bottom upward, and the round map is a bijection for any fixed input word.

An upstream counter stage supplies a 10-bit word per round. In the authenticated mode, the ciphertext bits of the previous round are also folded into the top bits of the state. The full state is presented in parallel to a downstream output combiner.

The input side uses a valid/ready handshake. `in_ready` is low while reset is held and high from the first clock edge after reset. The block never applies back-pressure after that, so a word is consumed on every edge where `in_valid` is high. An upstream stage that wants to pause simply drops `in_valid`, and the state then stays frozen. Nothing is buffered.

Top module: `vacc_accum`

## Requirements
- R1: While reset is asserted, `state_o` equals the INIT parameter (default 32'h6A09E667) and `in_ready` is 0. From the first clock edge after reset, `in_ready` is 1 and stays 1.
- R2: On a clock edge where `in_valid` and `in_ready` are not both high, `state_o` keeps its value, whatever `in_word`, `ct_bits` and `auth_mode` carry.
- R3: For an accepted word w and state s, the pre-permutation bits t[4:0] equal S(s[4:0]) XOR w[4:0]. Here S(x) is x cubed in GF(2^5) with reduction polynomial x^5+x^2+1, XOR 5'h0B.
- R4: For 5 ≤ i ≤ 9, t[i] = s[i] ^ w[i] ^ (s[i-1]&s[i-2]) ^ (s[i-3]&s[i-4]).
- R5: For 10 ≤ i < 32, t[i] = s[i] ^ (s[i-1]&s[i-2]) ^ (s[i-3]&s[i-4]) ^ s[i-5], plus the feedback of R6 where it applies.
- R6: When `auth_mode` is 1, ct_bits[j] is additionally XORed into t[24+j] for j = 0..7. When `auth_mode` is 0, `ct_bits` has no effect on the result.
- R7: The next state after an accepted word is given by next[(13*i+7) mod 32] = t[i]. The new value appears on `state_o` after the same clock edge that accepted the word.
- R8: The round is invertible. Undoing the permutation and then solving R3, R4, R5 and R6 from bit 0 upward, using the same word, ciphertext bits and mode, recovers the previous state exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Round clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Counter word present on `in_word` |
| in_ready | output | 1 | Block can take a word (low only during reset) |
| in_word | input | 10 | Counter diffusor word for this round |
| ct_bits | input | 8 | Previous round ciphertext bits |
| auth_mode | input | 1 | 1 enables ciphertext feedback |
| state_o | output | 32 | Parallel accumulator state |

## Verification
The hardest case to reach from the ports is a specific internal state. The state cannot be loaded, and every bit the S-box and nonlinear terms see is the result of earlier rounds scrambled through the permutation. The stimulus therefore runs long chains of rounds with directed and random words, in both feedback modes. The bench tracks its own model of the state, so that every S-box entry and bit pattern met along the way is checked. It also inverts each observed round in software and compares the result against the previously observed state.

// File: rtl/vacc_pkg.sv
package vacc_pkg;

  localparam int CNT_W = 10;
  localparam int SB_W = 5;
  localparam logic [SB_W-1:0] SBOX_XOR = 5'h0B;
  localparam logic [SB_W-1:0] GF_RED = 5'b00101;

  function automatic logic [SB_W-1:0] gf5_mul(input logic [SB_W-1:0] a,
                                              input logic [SB_W-1:0] b);
    logic [SB_W-1:0] acc;
    logic [SB_W-1:0] sh;
    acc = '0;
    sh = a;
    for (int k = 0; k < SB_W; k++) begin
      if (b[k]) acc = acc ^ sh;
      sh = {sh[SB_W-2:0], 1'b0} ^ (sh[SB_W-1] ? GF_RED : '0);
    end
    return acc;
  endfunction

  function automatic logic [SB_W-1:0] sbox5(input logic [SB_W-1:0] x);
    return gf5_mul(gf5_mul(x, x), x) ^ SBOX_XOR;
  endfunction

  function automatic logic nl4(input logic a, input logic b,
                               input logic c, input logic d);
    return (a & b) ^ (c & d);
  endfunction

endpackage

// File: rtl/vacc_low_layer.sv
module vacc_low_layer
  import vacc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] s_low,
  input  logic [CNT_W-1:0] word,
  output logic [CNT_W-1:0] t_low
);

  assign t_low[SB_W-1:0] = sbox5(s_low[SB_W-1:0]) ^ word[SB_W-1:0];

  for (genvar i = SB_W; i < CNT_W; i++) begin : g_mid
    assign t_low[i] = s_low[i] ^ word[i] ^
                      nl4(s_low[i-1], s_low[i-2], s_low[i-3], s_low[i-4]);
  end

  AST_SBOX_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    (s_low[SB_W-1:0] == '0) |-> ((t_low[SB_W-1:0] ^ word[SB_W-1:0]) == SBOX_XOR)); // R3

endmodule

// File: rtl/vacc_high_layer.sv
module vacc_high_layer
  import vacc_pkg::*;
#(
  parameter int W    = 32,
  parameter int CT_W = 8
) (
  input  logic [W-1:SB_W]  s_up,
  input  logic [CT_W-1:0]  ct,
  input  logic             fb_en,
  output logic [W-1:CNT_W] t_high
);

  localparam int FB_LO = W - CT_W;

  logic [CT_W-1:0] fb;
  assign fb = fb_en ? ct : '0;

  for (genvar i = CNT_W; i < W; i++) begin : g_bit
    logic core;
    assign core = s_up[i] ^ nl4(s_up[i-1], s_up[i-2], s_up[i-3], s_up[i-4]) ^ s_up[i-5];
    if (i >= FB_LO) begin : g_fb
      assign t_high[i] = core ^ fb[i-FB_LO];
    end else begin : g_plain
      assign t_high[i] = core;
    end
  end

endmodule

// File: rtl/vacc_permute.sv
module vacc_permute #(
  parameter int W        = 32,
  parameter int PERM_MUL = 13,
  parameter int PERM_ADD = 7
) (
  input  logic [W-1:0] t_in,
  output logic [W-1:0] p_out
);

  for (genvar i = 0; i < W; i++) begin : g_wire
    localparam int DST = (PERM_MUL * i + PERM_ADD) % W;
    assign p_out[DST] = t_in[i];
  end

endmodule

// File: rtl/vacc_accum.sv
module vacc_accum
  import vacc_pkg::*;
#(
  parameter int          W        = 32,
  parameter int          CT_W     = 8,
  parameter int          PERM_MUL = 13,
  parameter int          PERM_ADD = 7,
  parameter logic [W-1:0] INIT    = 'h6A09E667
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CNT_W-1:0] in_word,
  input  logic [CT_W-1:0]  ct_bits,
  input  logic             auth_mode,
  output logic [W-1:0]     state_o
);

  logic [W-1:0] state_q;
  logic         ready_q;
  logic [W-1:0] t_all;
  logic [W-1:0] p_all;
  logic         accept;

  assign accept   = in_valid & ready_q;
  assign in_ready = ready_q;
  assign state_o  = state_q;

  vacc_low_layer u_low (
    .clk   (clk),
    .rst_n (rst_n),
    .s_low (state_q[CNT_W-1:0]),
    .word  (in_word),
    .t_low (t_all[CNT_W-1:0])
  );

  vacc_high_layer #(.W(W), .CT_W(CT_W)) u_high (
    .s_up   (state_q[W-1:SB_W]),
    .ct     (ct_bits),
    .fb_en  (auth_mode),
    .t_high (t_all[W-1:CNT_W])
  );

  vacc_permute #(.W(W), .PERM_MUL(PERM_MUL), .PERM_ADD(PERM_ADD)) u_perm (
    .t_in  (t_all),
    .p_out (p_all)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= INIT;
      ready_q <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      if (accept) state_q <= p_all;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(state_o)); // R2

  AST_MOVE_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(state_o) |-> $past(in_valid && in_ready)); // R2

  AST_READY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready); // R1

  AST_PERM_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(t_all) == $countones(p_all)); // R7

endmodule

// File: tb/vacc_accum_tb.sv
module vacc_accum_tb_top;

  localparam logic [31:0] INIT_V = 32'h6A09E667;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [9:0]  in_word = '0;
  logic [7:0]  ct_bits = '0;
  logic        auth_mode = 1'b0;
  logic [31:0] state_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] model;
  logic [4:0]  sinv [32];

  always #2.5 clk = ~clk;

  vacc_accum dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .ct_bits(ct_bits), .auth_mode(auth_mode), .state_o(state_o)
  );

  function automatic logic [4:0] m_mul(input logic [4:0] a, input logic [4:0] b);
    logic [4:0] r = '0;
    logic [4:0] x = a;
    for (int k = 0; k < 5; k++) begin
      if (b[k]) r ^= x;
      x = x[4] ? ({x[3:0], 1'b0} ^ 5'h05) : {x[3:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [4:0] m_sbox(input logic [4:0] x);
    return m_mul(m_mul(x, x), x) ^ 5'h0B;
  endfunction

  function automatic int m_dst(input int i);
    return (13 * i + 7) % 32;
  endfunction

  function automatic logic [31:0] m_round(input logic [31:0] s, input logic [9:0] w,
                                          input logic [7:0] c, input logic md);
    logic [31:0] t;
    logic [31:0] n;
    t[4:0] = m_sbox(s[4:0]) ^ w[4:0];
    for (int i = 5; i < 10; i++)
      t[i] = s[i] ^ w[i] ^ (s[i-1] & s[i-2]) ^ (s[i-3] & s[i-4]);
    for (int i = 10; i < 32; i++) begin
      t[i] = s[i] ^ (s[i-1] & s[i-2]) ^ (s[i-3] & s[i-4]) ^ s[i-5];
      if (md && i >= 24) t[i] ^= c[i-24];
    end
    for (int i = 0; i < 32; i++) n[m_dst(i)] = t[i];
    return n;
  endfunction

  function automatic logic [31:0] m_inv(input logic [31:0] n, input logic [9:0] w,
                                        input logic [7:0] c, input logic md);
    logic [31:0] t;
    logic [31:0] s;
    for (int i = 0; i < 32; i++) t[i] = n[m_dst(i)];
    s[4:0] = sinv[t[4:0] ^ w[4:0]];
    for (int i = 5; i < 10; i++)
      s[i] = t[i] ^ w[i] ^ (s[i-1] & s[i-2]) ^ (s[i-3] & s[i-4]);
    for (int i = 10; i < 32; i++) begin
      s[i] = t[i] ^ (s[i-1] & s[i-2]) ^ (s[i-3] & s[i-4]) ^ s[i-5];
      if (md && i >= 24) s[i] ^= c[i-24];
    end
    return s;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one item per cycle
  task automatic step(input bit v, input logic [9:0] w, input logic [7:0] c,
                      input logic md, input string tag);
    @(negedge clk);
    in_valid = v; in_word = w; ct_bits = c; auth_mode = md;
    if (v) model = m_round(model, w, c, md);
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, state_o, e);
      end
    end
  end

  task automatic drain();
    @(negedge clk); in_valid = 1'b0;
    exp_q.push_back(model); tag_q.push_back("R2 drain");
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5ns * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int x = 0; x < 32; x++) sinv[m_sbox(5'(x))] = 5'(x);
    model = INIT_V;

    repeat (3) @(negedge clk);
    check("R1 state in reset", state_o, INIT_V);
    check("R1 ready low in reset", {31'b0, in_ready}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", {31'b0, in_ready}, 32'd1);
    check("R1 state after reset", state_o, INIT_V);

    // R2: junk on inputs without valid
    step(0, 10'h3FF, 8'hFF, 1, "R2 idle junk");
    step(0, 10'h155, 8'hA5, 0, "R2 idle junk");

    // R3 / R4 / R5 / R7: plain mode, directed words
    step(1, 10'h000, 8'h00, 0, "R5 R7 zero word");
    step(1, 10'h01F, 8'h00, 0, "R3 low word bits");
    step(1, 10'h3E0, 8'h00, 0, "R4 mid word bits");
    step(1, 10'h3FF, 8'h00, 0, "R3 R4 all ones");
    for (int k = 0; k < 40; k++)
      step(1, 10'(k * 37 + 5), 8'h00, 0, "R3 R4 R5 R7 sweep");
    step(0, 10'h2AA, 8'h00, 0, "R2 pause mid stream");

    // R6: ciphertext ignored when feedback off
    for (int k = 0; k < 12; k++)
      step(1, 10'(k * 91), 8'(8'hC3 ^ k), 0, "R6 ct ignored off");
    // R6: feedback on
    for (int k = 0; k < 24; k++)
      step(1, 10'($urandom), 8'($urandom), 1, "R6 ct feedback on");
    step(1, 10'h000, 8'h80, 1, "R6 single ct bit");
    step(1, 10'h000, 8'h01, 1, "R6 single ct bit");
    drain();

    // long random run over both modes
    for (int k = 0; k < 300; k++)
      step(($urandom % 4) != 0, 10'($urandom), 8'($urandom), 1'($urandom),
           "R2 R5 R6 random");
    drain();

    // R8: software inverse of each observed round
    for (int k = 0; k < 60; k++) begin
      logic [31:0] prev;
      logic [9:0] w;
      logic [7:0] c;
      logic md;
      prev = state_o;
      w = 10'($urandom); c = 8'($urandom); md = 1'($urandom);
      step(1, w, c, md, "R8 round");
      @(posedge clk); #2;
      check("R8 inverse recovers prior state", m_inv(state_o, w, c, md), prev);
    end
    drain();

    finish_run();
  end

endmodule